// File: doc/BRIEF.md
# Reset Cause and Request Register Block

This block is the software-facing register file of a reset controller. Software uses it to ask for a full system reset and to find out why the device last came out of reset. It also holds a bank of peripheral reset controls that software drives and can lock. The reset request is a 4-bit multi-bit boolean. The request line rises only while the field holds the true code, and hardware puts the field back to false when the reset-complete strobe arrives. The cause register gathers one sticky flag per reset source, and software clears each flag by writing one to it.

Each of the eight peripheral resets is active low and has a lock bit. Once software writes zero to a lock bit, the lock stays cleared until the block itself is reset, and any later write to that control is ignored. Accesses use a plain single-cycle register bus with byte addresses. Read data is combinational in the cycle that read enable is high, and a write takes effect at the next clock edge. Reset sequencing, clock-domain crossing and bus integrity are handled elsewhere.

Top module: `rst_cause_regs`

## Requirements
- R1: After reset, the request field (offset 0x4) reads 0x9 and the cause register (offset 0x8) reads 0x01. Every lock bit and every control bit reads 1, `sys_rst_req_o` is 0 and `periph_rst_no` is all ones.
- R2: `sys_rst_req_o` is 1 only while the request field holds 0x6. Every other value written to bits 3:0 at offset 0x4 (for example 0x0, 0x9 or 0xF) leaves it at 0.
- R3: A `reset_done_i` pulse while the field holds 0x6 returns the field to 0x9 and sets cause bit 2 at the next edge. If a bus write hits offset 0x4 in the same cycle, the completion takes priority over the write.
- R4: A `reset_done_i` pulse while the field does not hold 0x6 leaves the field unchanged and does not set cause bit 2.
- R5: A cycle with `por_i` high sets cause bit 0 at the next edge. A cycle with `lp_exit_i` high sets cause bit 1 at the next edge.
- R6: In a cycle with `reset_done_i` high, each `hw_req_i[k]` that is high sets cause bit 3+k. A hardware request line that is high without the strobe sets nothing.
- R7: Writing to offset 0x8 clears every cause bit whose write-data bit is 1 and leaves the others unchanged. A set event in the same cycle takes priority over the clear.
- R8: Lock bit i sits at bit 0 of offset 0x2c+4*i. Writing 0 clears it. Writing 1 never sets it again.
- R9: Control bit i sits at bit 0 of offset 0x4c+4*i and drives `periph_rst_no[i]` (0 holds the peripheral in reset). Writes to it are ignored while lock bit i is 0.
- R10: Reserved bits read 0 and writes to them are ignored. Unmapped or unaligned addresses (for example 0x05, 0x6c, 0x70) read 0 and writes to them change nothing. `bus_rdata_o` is 0 while `bus_re_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the read cycle |
| por_i | input | 1 | Power-on reset indication |
| lp_exit_i | input | 1 | Low-power-exit reset indication |
| hw_req_i | input | 5 | Hardware reset request lines |
| reset_done_i | input | 1 | Reset-complete strobe |
| sys_rst_req_o | output | 1 | System reset request |
| periph_rst_no | output | 8 | Active-low peripheral reset holds |

## Verification
Every register update, whether from a bus write, a completion strobe or a cause event, becomes visible one clock edge after the cycle of the stimulus. `sys_rst_req_o` and `periph_rst_no` follow that state without any further delay, and read data reflects the registers in the same cycle that read enable is high. The bench drives its inputs on falling edges and updates a behavioural model on each rising edge. It compares the two outputs 1 ns after that rising edge and checks each read 1 ns after the falling edge that presents it. Every comparison therefore sees exactly one edge of update. The same-cycle cases (completion together with a write, set together with a write-one-to-clear) are driven within a single cycle so that their priority shows up at that one edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam logic [3:0] MB4_TRUE  = 4'h6;
  localparam logic [3:0] MB4_FALSE = 4'h9;

  localparam int REQ_OFS   = 'h04;
  localparam int CAUSE_OFS = 'h08;
  localparam int LOCK_BASE = 'h2c;
  localparam int CTRL_BASE = 'h4c;
  localparam int REG_STRIDE = 4;

  localparam int CAUSE_POR = 0;
  localparam int CAUSE_LPE = 1;
  localparam int CAUSE_SW  = 2;
  localparam int CAUSE_HW0 = 3;
endpackage

// File: rtl/rstc_req_reg.sv
module rstc_req_reg
  import rstc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [3:0] wr_val_i,
  input  logic       done_i,
  output logic [3:0] field_o,
  output logic       active_o,
  output logic       done_hit_o
);
  logic [3:0] field_q, field_d;
  logic       field_en;

  assign active_o   = (field_q == MB4_TRUE);
  assign done_hit_o = done_i & active_o;
  assign field_o    = field_q;

  // completion beats a concurrent bus write
  always_comb begin
    field_d  = field_q;
    field_en = 1'b0;
    if (done_hit_o) begin
      field_d  = MB4_FALSE;
      field_en = 1'b1;
    end else if (wr_en_i) begin
      field_d  = wr_val_i;
      field_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= MB4_FALSE;
    end else if (field_en) begin
      field_q <= field_d;
    end
  end
endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] cause_o
);
  logic [W-1:0] cause_q, cause_d, clr_mask;
  logic         cause_en;

  always_comb begin
    clr_mask = clr_en_i ? clr_i : '0;
    cause_d  = (cause_q & ~clr_mask) | set_i;
    cause_en = clr_en_i | (|set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= W'(1);
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/rstc_swrst_slice.sv
module rstc_swrst_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_wr_i,
  input  logic ctrl_wr_i,
  input  logic wbit_i,
  output logic lock_o,
  output logic ctrl_o
);
  logic lock_q, lock_en;
  logic ctrl_q, ctrl_d, ctrl_en;

  always_comb begin
    lock_en = lock_wr_i & ~wbit_i;
    ctrl_en = ctrl_wr_i & lock_q;
    ctrl_d  = wbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b1;
    end else if (lock_en) begin
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= 1'b1;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign lock_o = lock_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rst_cause_regs.sv
module rst_cause_regs
  import rstc_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NUM_SWRST = 8,
  parameter int NUM_HWREQ = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_we_i,
  input  logic                 bus_re_i,
  input  logic [AW-1:0]        bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic                 por_i,
  input  logic                 lp_exit_i,
  input  logic [NUM_HWREQ-1:0] hw_req_i,
  input  logic                 reset_done_i,
  output logic                 sys_rst_req_o,
  output logic [NUM_SWRST-1:0] periph_rst_no
);
  localparam int CW = CAUSE_HW0 + NUM_HWREQ;

  logic [3:0]           req_field;
  logic                 req_active, done_hit;
  logic                 req_wr, cause_wr;
  logic [CW-1:0]        cause_set, cause_q;
  logic [NUM_SWRST-1:0] lock_q, ctrl_q;
  logic [NUM_SWRST-1:0] lock_hit, ctrl_hit;
  logic [31:0]          unused_wdata;

  assign unused_wdata = bus_wdata_i;
  assign req_wr   = bus_we_i && (bus_addr_i == AW'(REQ_OFS));
  assign cause_wr = bus_we_i && (bus_addr_i == AW'(CAUSE_OFS));

  rstc_req_reg u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (req_wr),
    .wr_val_i   (bus_wdata_i[3:0]),
    .done_i     (reset_done_i),
    .field_o    (req_field),
    .active_o   (req_active),
    .done_hit_o (done_hit)
  );

  assign cause_set = {hw_req_i & {NUM_HWREQ{reset_done_i}}, done_hit, lp_exit_i, por_i};

  rstc_cause_reg #(.W(CW)) u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cause_set),
    .clr_en_i (cause_wr),
    .clr_i    (bus_wdata_i[CW-1:0]),
    .cause_o  (cause_q)
  );

  for (genvar i = 0; i < NUM_SWRST; i++) begin : g_swrst
    assign lock_hit[i] = (bus_addr_i == AW'(LOCK_BASE + REG_STRIDE * i));
    assign ctrl_hit[i] = (bus_addr_i == AW'(CTRL_BASE + REG_STRIDE * i));

    rstc_swrst_slice u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lock_wr_i (bus_we_i & lock_hit[i]),
      .ctrl_wr_i (bus_we_i & ctrl_hit[i]),
      .wbit_i    (bus_wdata_i[0]),
      .lock_o    (lock_q[i]),
      .ctrl_o    (ctrl_q[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i) begin
      if (bus_addr_i == AW'(REQ_OFS))   bus_rdata_o = {28'b0, req_field};
      if (bus_addr_i == AW'(CAUSE_OFS)) bus_rdata_o = 32'(cause_q);
      for (int i = 0; i < NUM_SWRST; i++) begin
        if (lock_hit[i]) bus_rdata_o = {31'b0, lock_q[i]};
        if (ctrl_hit[i]) bus_rdata_o = {31'b0, ctrl_q[i]};
      end
    end
  end

  assign sys_rst_req_o = req_active;
  assign periph_rst_no = ctrl_q;
endmodule

// File: rtl/rstc_chk.sv
module rstc_chk
  import rstc_pkg::*;
#(
  parameter int AW        = 8,
  parameter int NUM_SWRST = 8,
  parameter int CW        = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_we_i,
  input logic                 bus_re_i,
  input logic [AW-1:0]        bus_addr_i,
  input logic [31:0]          bus_rdata_o,
  input logic                 por_i,
  input logic                 reset_done_i,
  input logic                 sys_rst_req_o,
  input logic [CW-1:0]        cause_q,
  input logic [NUM_SWRST-1:0] lock_q,
  input logic [NUM_SWRST-1:0] ctrl_q
);
  // R2
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(bus_we_i && bus_addr_i == AW'(REQ_OFS)));

  // R3
  done_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && reset_done_i) |=> !sys_rst_req_o);

  // R3
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_rst_req_o && reset_done_i) |=> cause_q[CAUSE_SW]);

  // R5
  por_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> cause_q[CAUSE_POR]);

  // R8
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q & ~$past(lock_q)) == '0);

  // R9
  ctrl_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ctrl_q ^ $past(ctrl_q)) & ~$past(lock_q)) == '0);

  // R10
  rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |-> bus_rdata_o == '0);
endmodule

bind rst_cause_regs rstc_chk #(
  .AW(AW), .NUM_SWRST(NUM_SWRST), .CW(CW)
) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_we_i      (bus_we_i),
  .bus_re_i      (bus_re_i),
  .bus_addr_i    (bus_addr_i),
  .bus_rdata_o   (bus_rdata_o),
  .por_i         (por_i),
  .reset_done_i  (reset_done_i),
  .sys_rst_req_o (sys_rst_req_o),
  .cause_q       (cause_q),
  .lock_q        (lock_q),
  .ctrl_q        (ctrl_q)
);

// File: tb/rst_cause_regs_tb_top.sv
`timescale 1ns/1ps
module rst_cause_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        por = 1'b0, lpe = 1'b0, done = 1'b0;
  logic [4:0]  hw = '0;
  logic        sys_req;
  logic [7:0]  periph;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rst_cause_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .por_i(por), .lp_exit_i(lpe), .hw_req_i(hw), .reset_done_i(done),
    .sys_rst_req_o(sys_req), .periph_rst_no(periph)
  );

  // behavioural reference model
  int        m_req;
  int        m_cause;
  bit [7:0]  m_lock, m_ctrl;

  task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 9; m_cause = 1; m_lock = '1; m_ctrl = '1;
    end else begin
      bit fin;
      int clr;
      bit [7:0] lk;
      fin = done && (m_req == 6);
      clr = (we && addr == 8'h08) ? int'(wdata[7:0]) : 0;
      lk  = m_lock;
      if (fin) m_req = 9;
      else if (we && addr == 8'h04) m_req = int'(wdata[3:0]);
      m_cause = (m_cause & ~clr) | (por ? 1 : 0) | (lpe ? 2 : 0) | (fin ? 4 : 0)
                | (done ? (int'(hw) << 3) : 0);
      for (int i = 0; i < 8; i++) begin
        if (we && addr == 8'(8'h2c + 4 * i) && !wdata[0]) m_lock[i] = 1'b0;
        if (we && addr == 8'(8'h4c + 4 * i) && lk[i]) m_ctrl[i] = wdata[0];
      end
    end
    #1;
    check32("R2 sys_rst_req_o vs model", 32'(sys_req), 32'(m_req == 6));
    check32("R9 periph_rst_no vs model", 32'(periph), 32'(m_ctrl));
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      we = 0; re = 0; done = 0; por = 0; lpe = 0;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1; re = 0; addr = a; wdata = d; done = 0; por = 0; lpe = 0;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    we = 0; re = 1; addr = a; done = 0; por = 0; lpe = 0;
    #1;
    check32(tag, rdata, exp);
    @(negedge clk);
    re = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    we = 0; re = 0; done = 1;
    @(negedge clk);
    done = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1 reset values
    rd(8'h04, 32'h9, "R1 request field reset");
    rd(8'h08, 32'h1, "R1 cause reset");
    rd(8'h2c, 32'h1, "R1 lock0 reset");
    rd(8'h68, 32'h1, "R1 ctrl7 reset");
    check32("R1 periph reset", 32'(periph), 32'hFF);
    check32("R1 sys_req reset", 32'(sys_req), 32'h0);

    // R2 only 0x6 requests
    wr(8'h04, 32'hF);
    rd(8'h04, 32'hF, "R2 field 0xF readback");
    check32("R2 0xF not true", 32'(sys_req), 0);
    wr(8'h04, 32'h0);
    check32("R2 0x0 not true", 32'(sys_req), 0);
    wr(8'h04, 32'hABCD_EF06);
    rd(8'h04, 32'h6, "R10 reserved bits of request read zero");
    check32("R2 0x6 requests", 32'(sys_req), 1);

    // R3 completion
    pulse_done();
    rd(8'h04, 32'h9, "R3 field back to false");
    rd(8'h08, 32'h5, "R3 sw cause set");
    check32("R3 request dropped", 32'(sys_req), 0);

    // R4 completion without active request
    pulse_done();
    rd(8'h04, 32'h9, "R4 field unchanged");
    wr(8'h08, 32'h4);
    rd(8'h08, 32'h1, "R7 sw cause cleared");
    pulse_done();
    rd(8'h08, 32'h1, "R4 sw cause not set");

    // R3 completion beats concurrent write
    wr(8'h04, 32'h6);
    @(negedge clk);
    we = 1; addr = 8'h04; wdata = 32'h6; done = 1;
    @(negedge clk);
    we = 0; done = 0;
    rd(8'h04, 32'h9, "R3 completion wins over write");
    rd(8'h08, 32'h5, "R3 sw cause on tie");

    // R6 hardware requests
    @(negedge clk);
    hw = 5'b10101; done = 1;
    @(negedge clk);
    done = 0; hw = 5'b01010;
    idle(2);
    rd(8'h08, 32'hAD, "R6 hw cause bits with strobe");
    hw = '0;
    rd(8'h08, 32'hAD, "R6 hw lines without strobe set nothing");

    // R7 W1C and set priority
    wr(8'h08, 32'h28);
    rd(8'h08, 32'h85, "R7 partial clear");
    @(negedge clk);
    we = 1; addr = 8'h08; wdata = 32'hFF; por = 1;
    @(negedge clk);
    we = 0; por = 0;
    rd(8'h08, 32'h1, "R7 set wins over clear");

    // R5 por / lp exit
    @(negedge clk);
    lpe = 1;
    @(negedge clk);
    lpe = 0;
    rd(8'h08, 32'h3, "R5 lp exit sets bit1");
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h2, "R7 por cleared");
    @(negedge clk);
    por = 1;
    @(negedge clk);
    por = 0;
    rd(8'h08, 32'h3, "R5 por sets bit0");

    // R9 controls
    wr(8'h58, 32'h0);
    rd(8'h58, 32'h0, "R9 ctrl3 readback 0");
    check32("R9 periph3 held", 32'(periph), 32'hF7);
    wr(8'h58, 32'h1);
    check32("R9 periph3 released", 32'(periph), 32'hFF);
    wr(8'h58, 32'h0);

    // R8 lock
    wr(8'h38, 32'h1);
    rd(8'h38, 32'h1, "R8 write 1 keeps lock");
    wr(8'h38, 32'h0);
    rd(8'h38, 32'h0, "R8 write 0 clears lock");
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, 32'h0, "R8 lock cannot be set again");
    wr(8'h58, 32'h1);
    rd(8'h58, 32'h0, "R9 locked ctrl ignores write");
    check32("R9 locked periph3 stays held", 32'(periph), 32'hF7);
    wr(8'h4c, 32'hFFFF_FFFE);
    rd(8'h4c, 32'h0, "R9 unlocked ctrl0 written");
    check32("R9 periph0 held", 32'(periph), 32'hF6);

    // R10 unmapped / unaligned / idle read
    wr(8'h70, 32'hFFFF_FFFF);
    wr(8'h05, 32'h0);
    rd(8'h04, 32'h9, "R10 unaligned write ignored");
    rd(8'h70, 32'h0, "R10 unmapped reads zero");
    rd(8'h6c, 32'h0, "R10 offset 0x6c reads zero");
    rd(8'h08, 32'h3, "R10 cause untouched by unmapped writes");
    @(negedge clk);
    re = 0; addr = 8'h04;
    #1;
    check32("R10 rdata zero when idle", rdata, 32'h0);
    idle(2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule